// File: doc/BRIEF.md
# GPIO Edge Event Status Unit

This block watches a bank of already-filtered GPIO inputs and turns their transitions into two latched event sets. One set is the "assert" set and the other is the "deassert" set. Each pin has its own sense bit. With the sense bit at 1, a rising edge counts as an assert event and a falling edge counts as a deassert event. With the sense bit at 0 the two are swapped. Taking both sets together gives detection on both edges. A pin's events are latched only while its enable bit is set. Each event set drives its own interrupt line, and a line is high while any of its latched bits has its enable bit set.

Software reaches four registers through a single-cycle port: a combinational read and a write that takes effect on the clock edge. In both status registers the pins sit one bit position higher than their index, and bit 0 selects how the rest of the word is applied. With bit 0 at 1, each bit written as 1 is set. With bit 0 at 0, each bit written as 1 is cleared. In both cases, bits written as 0 keep their value. Software can therefore acknowledge or inject chosen events in a single write. An edge detected in the same cycle as a clear keeps its bit set, so no event is lost.

Top module: `gpio_evt_unit`

## Requirements
- R1: Register addresses are 0 for enable, 1 for sense, 2 for assert status and 3 for deassert status. In the enable and sense registers, pin n sits at bit n. In both status registers, pin n sits at bit n+1, and bit 0 always reads back as 0.
- R2: A status write with bit 0 equal to 0 clears every status bit written as 1 and leaves the other bits unchanged.
- R3: A status write with bit 0 equal to 1 sets every status bit written as 1 and leaves the other bits unchanged. The status bits change only on a write or an edge event.
- R4: With sense bit 1 and enable bit 1, a rising edge on a pin sets its assert status bit, and a falling edge sets its deassert status bit.
- R5: With sense bit 0 and enable bit 1, a falling edge on a pin sets its assert status bit, and a rising edge sets its deassert status bit.
- R6: A pin whose enable bit is 0 latches no event in either status register.
- R7: When an edge event occurs in the same cycle as a software clear of that bit, the bit stays set.
- R8: The assert interrupt is the OR of the assert status bits masked by the enable bits, and the deassert interrupt is formed the same way from the deassert status. Each output depends only on its own status register.
- R9: After reset the enable, sense and both status registers read 0, and both interrupts are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | NPINS | Filtered GPIO levels |
| reg_addr_i | input | 2 | Register select |
| reg_we_i | input | 1 | Write strobe, taken at the clock edge |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Combinational read data for reg_addr_i |
| irq_assert_o | output | 1 | Assert-event interrupt |
| irq_deassert_o | output | 1 | Deassert-event interrupt |

## Verification
Each pin is toggled on its own under both sense settings. A rise followed by a fall shows whether the event reaches the correct register and the correct bit position, and shows whether the bit is offset by one. Multi-pin flip patterns under a mixed sense word and a partial enable mask show whether pins affect one another and whether masked pins stay silent. Software set and clear writes with selected bits, including a word that carries only the mode bit, separate the two write modes from the no-change case. A clear that lands in the same cycle as an edge shows which of the two takes priority.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;
  typedef enum logic [1:0] {
    RA_ENABLE   = 2'd0,
    RA_SENSE    = 2'd1,
    RA_ASSERT   = 2'd2,
    RA_DEASSERT = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/gpio_evt_edge.sv
module gpio_evt_edge #(
  parameter int NPINS = 31
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_i,
  output logic [NPINS-1:0] rise_o,
  output logic [NPINS-1:0] fall_o
);
  logic [NPINS-1:0] prev_q;
  logic             primed_q;

  // The first sample after reset only seeds prev_q.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= '0;
      primed_q <= 1'b0;
    end else begin
      prev_q   <= pin_i;
      primed_q <= 1'b1;
    end
  end

  assign rise_o = primed_q ? (pin_i & ~prev_q) : '0;
  assign fall_o = primed_q ? (~pin_i & prev_q) : '0;

  AST_EDGE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_o & fall_o) == '0); // R4
endmodule

// File: rtl/gpio_evt_route.sv
module gpio_evt_route #(
  parameter int NPINS = 31
) (
  input  logic [NPINS-1:0] en_i,
  input  logic [NPINS-1:0] sense_i,
  input  logic [NPINS-1:0] rise_i,
  input  logic [NPINS-1:0] fall_i,
  output logic [NPINS-1:0] asrt_o,
  output logic [NPINS-1:0] dsrt_o
);
  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    assign asrt_o[g] = en_i[g] & (sense_i[g] ? rise_i[g] : fall_i[g]);
    assign dsrt_o[g] = en_i[g] & (sense_i[g] ? fall_i[g] : rise_i[g]);
  end
endmodule

// File: rtl/gpio_evt_status.sv
module gpio_evt_status #(
  parameter int NPINS = 31
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [NPINS:0]   wdata_i,
  input  logic [NPINS-1:0] evt_i,
  output logic [NPINS-1:0] stat_o
);
  logic [NPINS-1:0] stat_q;

  // Bit 0 of the word picks set (1) or clear (0); the upper bits select pins.
  function automatic logic [NPINS-1:0] apply_write(input logic [NPINS-1:0] cur,
                                                   input logic [NPINS:0]   w);
    return w[0] ? (cur | w[NPINS:1]) : (cur & ~w[NPINS:1]);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else if (wr_i) stat_q <= apply_write(stat_q, wdata_i) | evt_i;
    else stat_q <= stat_q | evt_i;
  end

  assign stat_o = stat_q;

  AST_CLEAR_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i && !wdata_i[0] |=> (stat_q & ~$past(evt_i)) ==
      ($past(stat_q) & ~$past(wdata_i[NPINS:1]) & ~$past(evt_i))); // R2
  AST_SET_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i && wdata_i[0] |=> stat_q ==
      ($past(stat_q) | $past(wdata_i[NPINS:1]) | $past(evt_i))); // R3
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i && evt_i == '0 |=> $stable(stat_q)); // R3
  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    evt_i != '0 |=> (stat_q & $past(evt_i)) == $past(evt_i)); // R7
endmodule

// File: rtl/gpio_evt_unit.sv
module gpio_evt_unit #(
  parameter int NPINS  = 31,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPINS-1:0]  pin_i,
  input  logic [1:0]        reg_addr_i,
  input  logic              reg_we_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_assert_o,
  output logic              irq_deassert_o
);
  import gpio_evt_pkg::*;

  localparam int STAT_W = NPINS + 1;

  logic [NPINS-1:0] en_q, sense_q;
  logic [NPINS-1:0] rise_w, fall_w, asrt_evt, dsrt_evt;
  logic [NPINS-1:0] as_stat, ds_stat;
  logic             wr_as, wr_ds;

  initial if (DATA_W < STAT_W) $error("DATA_W must hold NPINS+1 bits");

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '0;
      sense_q <= '0;
    end else if (reg_we_i) begin
      if (reg_addr_i == RA_ENABLE) en_q    <= reg_wdata_i[NPINS-1:0];
      if (reg_addr_i == RA_SENSE)  sense_q <= reg_wdata_i[NPINS-1:0];
    end
  end

  assign wr_as = reg_we_i && (reg_addr_i == RA_ASSERT);
  assign wr_ds = reg_we_i && (reg_addr_i == RA_DEASSERT);

  gpio_evt_edge #(.NPINS(NPINS)) u_edge (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .rise_o(rise_w), .fall_o(fall_w));

  gpio_evt_route #(.NPINS(NPINS)) u_route (
    .en_i(en_q), .sense_i(sense_q), .rise_i(rise_w), .fall_i(fall_w),
    .asrt_o(asrt_evt), .dsrt_o(dsrt_evt));

  gpio_evt_status #(.NPINS(NPINS)) u_as (
    .clk(clk), .rst_n(rst_n), .wr_i(wr_as), .wdata_i(reg_wdata_i[STAT_W-1:0]),
    .evt_i(asrt_evt), .stat_o(as_stat));

  gpio_evt_status #(.NPINS(NPINS)) u_ds (
    .clk(clk), .rst_n(rst_n), .wr_i(wr_ds), .wdata_i(reg_wdata_i[STAT_W-1:0]),
    .evt_i(dsrt_evt), .stat_o(ds_stat));

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      RA_ENABLE:   reg_rdata_o[NPINS-1:0] = en_q;
      RA_SENSE:    reg_rdata_o[NPINS-1:0] = sense_q;
      RA_ASSERT:   reg_rdata_o[STAT_W-1:1] = as_stat;
      default:     reg_rdata_o[STAT_W-1:1] = ds_stat;
    endcase
  end

  assign irq_assert_o   = |(as_stat & en_q);
  assign irq_deassert_o = |(ds_stat & en_q);

  AST_MODE_BIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    reg_addr_i[1] |-> reg_rdata_o[0] == 1'b0); // R1
  AST_MASKED_NO_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    ((asrt_evt | dsrt_evt) & ~en_q) == '0); // R6
  AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_assert_o |-> as_stat != '0) and (irq_deassert_o |-> ds_stat != '0)); // R8
endmodule

// File: tb/gpio_evt_unit_tb_top.sv
module gpio_evt_unit_tb_top;
  localparam int NP = 31;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] pin = '0;
  logic [1:0]    addr = 2'd0;
  logic          we = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          irq_a, irq_d;

  int checks = 0;
  int errors = 0;

  logic [NP-1:0] m_en = '0, m_sense = '0, m_as = '0, m_ds = '0;

  always #10 clk = ~clk;

  gpio_evt_unit #(.NPINS(NP), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .pin_i(pin), .reg_addr_i(addr), .reg_we_i(we),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_assert_o(irq_a),
    .irq_deassert_o(irq_d));

  function automatic logic [NP-1:0] sw_apply(input logic [NP-1:0] s, input logic [DW-1:0] w);
    logic [NP-1:0] sel = w[NP:1];
    return w[0] ? (s | sel) : (s & ~sel);
  endfunction

  task automatic chk(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic rd(input string tag, input logic [1:0] a, input logic [DW-1:0] exp);
    addr = a;
    #1;
    chk(tag, rdata, exp);
  endtask

  task automatic check_all(input string tag);
    rd({tag, " assert status"}, 2'd2, {m_as, 1'b0});
    rd({tag, " deassert status"}, 2'd3, {m_ds, 1'b0});
    chk({tag, " R8 irq_assert"}, {31'd0, irq_a}, {31'd0, |(m_as & m_en)});
    chk({tag, " R8 irq_deassert"}, {31'd0, irq_d}, {31'd0, |(m_ds & m_en)});
  endtask

  // One clock step: new pin levels plus an optional register write.
  task automatic step(input logic [NP-1:0] nv, input logic w, input logic [1:0] a,
                      input logic [DW-1:0] d);
    logic [NP-1:0] rise, fall, ae, de;
    @(negedge clk);
    rise = nv & ~pin;
    fall = ~nv & pin;
    ae = m_en & ((m_sense & rise) | (~m_sense & fall));
    de = m_en & ((m_sense & fall) | (~m_sense & rise));
    pin = nv; we = w; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
    if (w) begin
      case (a)
        2'd0: m_en = d[NP-1:0];
        2'd1: m_sense = d[NP-1:0];
        2'd2: m_as = sw_apply(m_as, d);
        default: m_ds = sw_apply(m_ds, d);
      endcase
    end
    m_as = m_as | ae;
    m_ds = m_ds | de;
  endtask

  task automatic clear_both();
    step(pin, 1'b1, 2'd2, {{NP{1'b1}}, 1'b0});
    step(pin, 1'b1, 2'd3, {{NP{1'b1}}, 1'b0});
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    pin = {NP{1'b1}};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9: reset values
    rd("R9 enable reset", 2'd0, '0);
    rd("R9 sense reset", 2'd1, '0);
    check_all("R9 reset");

    // R1: enable and sense use pin n at bit n
    step(pin, 1'b1, 2'd0, 32'h7fff_ffff);
    rd("R1 enable readback", 2'd0, 32'h7fff_ffff);
    step(pin, 1'b1, 2'd1, 32'h1234_5678);
    rd("R1 sense readback", 2'd1, 32'h1234_5678);
    step('0, 1'b0, 2'd0, '0);
    clear_both();
    check_all("R1 cleared");

    // R4 / R5: single-pin sweep under both sense settings
    for (int s = 1; s >= 0; s--) begin
      step(pin, 1'b1, 2'd1, s ? 32'h7fff_ffff : 32'h0);
      for (int p = 0; p < NP; p++) begin
        step(pin | (31'd1 << p), 1'b0, 2'd0, '0);
        check_all(s ? "R4 rise" : "R5 rise");
        step(pin & ~(31'd1 << p), 1'b0, 2'd0, '0);
        check_all(s ? "R4 fall" : "R5 fall");
        clear_both();
      end
    end

    // R4/R5 mixed sense, multi-pin patterns
    step(pin, 1'b1, 2'd1, 32'h5555_5555);
    for (int k = 0; k < 8; k++) begin
      step(pin ^ (31'h2468_ace1 * (k + 1)), 1'b0, 2'd0, '0);
      check_all("R5 mixed pattern");
    end
    clear_both();

    // R6: partial enable mask
    step(pin, 1'b1, 2'd0, 32'h0000_ffff);
    step(~pin, 1'b0, 2'd0, '0);
    check_all("R6 masked flip");
    step(~pin, 1'b0, 2'd0, '0);
    check_all("R6 masked flip back");
    clear_both();

    // R3 / R2: software set, no-op, and selective clear
    step(pin, 1'b1, 2'd2, 32'hf000_000f);
    check_all("R3 set mode");
    step(pin, 1'b1, 2'd2, 32'h0000_0001);
    check_all("R3 mode bit only");
    step(pin, 1'b1, 2'd3, 32'h8000_0401);
    check_all("R3 set deassert");
    step(pin, 1'b1, 2'd2, 32'h1000_0006);
    check_all("R2 selective clear");
    step(pin, 1'b1, 2'd3, 32'h0000_0000);
    check_all("R2 clear nothing");

    // R8: status with enable off does not raise the line
    step(pin, 1'b1, 2'd0, 32'h0);
    check_all("R8 enables off");
    step(pin, 1'b1, 2'd0, 32'h4000_0000);
    check_all("R8 one enable");
    step(pin, 1'b1, 2'd0, 32'h7fff_ffff);
    clear_both();
    check_all("R8 after clear");

    // R7: edge and clear in the same cycle
    step(pin, 1'b1, 2'd1, 32'h7fff_ffff);
    step(pin & ~31'h60, 1'b0, 2'd0, '0);
    clear_both();
    step(pin, 1'b1, 2'd2, 32'h0000_0081);
    step(pin | 31'h20, 1'b1, 2'd2, 32'h0000_00c0);
    check_all("R7 event wins");
    chk("R7 pin5 held", {31'd0, m_as[5]}, 32'd1);

    finish_run();
  end
endmodule